// File: doc/BRIEF.md
# Synchronous Shift-Clock Serial Port

This block moves one byte at a time over a two-wire synchronous link: it drives a shift clock on one pin and carries data on a single bidirectional data pin, least significant bit first. The block is the master of the link, so the clock is always its own. The bit rate comes from a divisor input. A single-cycle transmit write loads a byte and starts sending it. A single-cycle receive start begins clocking a byte in from the far end. Every time unit below is one cycle of `clk`, the oscillator clock.

Each byte takes exactly eight clock pulses. The shift clock idles high. For each bit it is low for 2·D cycles, where D is the divisor (0 counts as 1), and then high for 2 cycles. On transmit, the data pin changes only when the shift clock falls. It then holds through the following rising edge. On receive, the data pin is sampled on the oscillator edge that raises the shift clock. At the end of a byte, the block releases the data pin one cycle after the last rising edge. One cycle later it goes idle and raises a done flag. Done flags and the error flag are sticky and are cleared by their own clear strobes.

The transmit and receive starts are plain strobes with no back-pressure. A start is accepted only while the block is idle. A transmit write that arrives during a transfer is dropped and recorded in the sticky error flag. The received byte is presented on `rx_byte` together with the `rx_done` flag. It stays there until the next reception completes.

Top module: `ssp_sync_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `sd_oe` is 0, and `busy`, `tx_done`, `rx_done` and `wr_err` are all 0.
- R2: A `tx_wr` pulse while idle sends `tx_byte` on `sd_o`, bit 0 first and bit 7 last. `sd_oe` is 1 from the first low phase until the final rising edge.
- R3: Every transfer produces exactly 8 falling and 8 rising shift-clock edges. Each low phase lasts 2·D cycles and each high phase lasts 2 cycles, where D is `rate_div` (a value of 0 is treated as 1).
- R4: During a transmit, `sd_o` changes only in the cycle where `sclk_o` falls. It is therefore stable for the whole high phase, including across the rising edge.
- R5: `sd_oe` falls 1 cycle after the final rising edge. `busy` falls and the done flag rises 2 cycles after that edge. `sclk_o` stays 1 afterwards.
- R6: An `rx_start` pulse while idle starts a reception with `sd_oe` held at 0. `sd_i` is captured at each edge that raises `sclk_o`, and the first capture is bit 0. At completion `rx_byte` holds the byte and `rx_done` is set.
- R7: A `tx_wr` while busy is ignored (the byte in flight is unchanged) and sets the sticky `wr_err`.
- R8: An `rx_start` while busy is ignored. If `tx_wr` and `rx_start` arrive in the same idle cycle, the transmit wins and the receive start is dropped.
- R9: `clr_tx_done`, `clr_rx_done` and `clr_err` each clear their flag on the next cycle. If a flag is set and cleared in the same cycle, the set wins.
- R10: `busy` is 1 from the cycle after an accepted start until the end of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_div | input | RATE_W | Bit-rate divisor D; low phase is 2·D cycles |
| tx_wr | input | 1 | Transmit write strobe |
| tx_byte | input | DATA_W | Byte to transmit |
| rx_start | input | 1 | Receive start strobe |
| clr_tx_done | input | 1 | Clear transmit-done flag |
| clr_rx_done | input | 1 | Clear receive-done flag |
| clr_err | input | 1 | Clear write-error flag |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin drive enable |
| sd_i | input | 1 | Data pin input value |
| rx_byte | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| tx_done | output | 1 | Sticky transmit-complete flag |
| rx_done | output | 1 | Sticky receive-complete flag |
| wr_err | output | 1 | Sticky flag for a transmit write while busy |

## Verification
Each transfer is traced cycle by cycle at the pins, and each low and high phase length is measured against the divisor, with divisor 0 and divisor 1 forming the boundary pair. A design that counted the low phase once too often, or treated 0 as a huge count, would show up as a wrong phase length or a hung transfer. The release of the data pin and the drop of `busy` are timed relative to the final rising edge. Releasing at the edge itself, or one cycle late, fails that check. Writes and receive starts are injected mid-transfer, and a transmit write is made to coincide with an error clear. A design that let the write reload the shifter, that started a receive over a transmit, or that gave the clear priority would corrupt the captured byte or leave the wrong flags.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } ssp_state_e;

  localparam int HIGH_CYCLES = 2;
  localparam int NUM_FLAGS   = 3;
  localparam int FLG_TXD     = 0;
  localparam int FLG_RXD     = 1;
  localparam int FLG_ERR     = 2;
endpackage

// File: rtl/ssp_phase_timer.sv
module ssp_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R3
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_out,
  input  logic         shift_in,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= load_val;
    else if (shift_out)
      q <= {1'b0, q[W-1:1]};
    else if (shift_in)
      q <= {sin, q[W-1:1]};
  end

  AST_ONE_SHIFT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load, shift_out, shift_in}) <= 1); // R2
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (set[i])
        q[i] <= 1'b1;
      else if (clr[i])
        q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R9
  end
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
  import ssp_pkg::*;
#(
  parameter int RATE_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_start,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              clr_err,
  output logic              sclk_o,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              tx_done,
  output logic              rx_done,
  output logic              wr_err
);
  localparam int CNT_W = RATE_W + 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  ssp_state_e        st_q;
  logic              sclk_q, oe_q, rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shr_q, rxb_q;
  logic [RATE_W-1:0] eff_div;
  logic [CNT_W-1:0]  low_m1, tmr_val;
  logic              tmr_zero, tmr_load;
  logic              start_tx, start_rx, last_bit, finish;
  logic              do_rise, do_fall;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q;

  // phase length: low = 2*D cycles, D of zero counts as one
  assign eff_div  = (rate_div == '0) ? RATE_W'(1) : rate_div;
  assign low_m1   = {eff_div, 1'b0} - CNT_W'(1);

  assign start_tx = tx_wr && (st_q == ST_IDLE);
  assign start_rx = rx_start && !tx_wr && (st_q == ST_IDLE);
  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
  assign do_rise  = (st_q == ST_LOW) && tmr_zero;
  assign do_fall  = (st_q == ST_HIGH) && tmr_zero && !last_bit;
  assign finish   = (st_q == ST_HIGH) && tmr_zero && last_bit;

  assign tmr_load = start_tx || start_rx || do_rise || do_fall;
  assign tmr_val  = do_rise ? CNT_W'(HIGH_CYCLES - 1) : low_m1;

  ssp_phase_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_tx || start_rx),
    .load_val  (start_tx ? tx_byte : '0),
    .shift_out (do_fall && !rx_q),
    .shift_in  (do_rise && rx_q),
    .sin       (sd_i),
    .q         (shr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b1;
      oe_q   <= 1'b0;
      rx_q   <= 1'b0;
      bit_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_tx || start_rx) begin
            st_q   <= ST_LOW;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            rx_q   <= start_rx;
            oe_q   <= start_tx;
          end
        end
        ST_LOW: begin
          if (tmr_zero) begin
            st_q   <= ST_HIGH;
            sclk_q <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (last_bit)
            oe_q <= 1'b0;            // release one cycle after final rise
          if (finish) begin
            st_q <= ST_IDLE;
          end else if (do_fall) begin
            st_q   <= ST_LOW;
            sclk_q <= 1'b0;
            bit_q  <= bit_q + BIT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rxb_q <= '0;
    else if (finish && rx_q)
      rxb_q <= shr_q;
  end

  assign flg_set[FLG_TXD] = finish && !rx_q;
  assign flg_set[FLG_RXD] = finish && rx_q;
  assign flg_set[FLG_ERR] = tx_wr && (st_q != ST_IDLE);
  assign flg_clr[FLG_TXD] = clr_tx_done;
  assign flg_clr[FLG_RXD] = clr_rx_done;
  assign flg_clr[FLG_ERR] = clr_err;

  ssp_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flg_set),
    .clr   (flg_clr),
    .q     (flg_q)
  );

  assign sclk_o  = sclk_q;
  assign sd_o    = shr_q[0];
  assign sd_oe   = oe_q;
  assign rx_byte = rxb_q;
  assign busy    = (st_q != ST_IDLE);
  assign tx_done = flg_q[FLG_TXD];
  assign rx_done = flg_q[FLG_RXD];
  assign wr_err  = flg_q[FLG_ERR];

  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |=> sclk_q); // R3
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |=> !sclk_q); // R3
  AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIGH && !rx_q) |-> $stable(sd_o)); // R4
  AST_END_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk_o && !sd_oe)); // R5
  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_q) |-> !sd_oe); // R6
  AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> wr_err); // R7
endmodule

// File: tb/tb_ssp_sync_port.sv
module tb_ssp_sync_port;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 15;
  localparam int NV = 8;
  // vector: {is_rx, divisor[15:0], data[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 16'd1, 8'hA5}, {1'b0, 16'd2, 8'h3C}, {1'b1, 16'd1, 8'h5A},
    {1'b1, 16'd3, 8'hC3}, {1'b0, 16'd0, 8'h81}, {1'b1, 16'd0, 8'h7E},
    {1'b0, 16'd5, 8'hFF}, {1'b1, 16'd2, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] rate_div = '0;
  logic tx_wr = 0, rx_start = 0, clr_tx_done = 0, clr_rx_done = 0, clr_err = 0, sd_i = 0;
  logic [7:0] tx_byte = '0;
  logic sclk_o, sd_o, sd_oe, busy, tx_done, rx_done, wr_err;
  logic [7:0] rx_byte;
  int n_chk = 0, n_bad = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_sync_port #(.RATE_W(RW), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .rx_start(rx_start), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
    .clr_err(clr_err), .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i),
    .rx_byte(rx_byte), .busy(busy), .tx_done(tx_done), .rx_done(rx_done), .wr_err(wr_err)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // inj: 0 none, 1 tx_wr mid, 2 rx_start mid, 3 tx_wr+clr_err mid, 4 tx_wr and rx_start at start
  task automatic run_xfer(input logic is_rx, input logic [15:0] div, input logic [7:0] data,
                          input int inj, input int inj_cyc);
    int exp_low, falls, rises, low_cnt, high_cnt, low_bad, high_bad, order_bad, oe_bad;
    int cyc, last_rise, oe_drop, busy_drop;
    logic [7:0] got;
    logic prev_sclk, prev_sdo, s;
    exp_low = (div == 0) ? 2 : 2 * int'(div);
    falls = 0; rises = 0; low_cnt = 0; high_cnt = 0; low_bad = 0; high_bad = 0;
    order_bad = 0; oe_bad = 0; last_rise = -1; oe_drop = -1; busy_drop = -1; got = '0;
    @(negedge clk);
    rate_div = RW'(div); tx_byte = data; sd_i = data[0];
    if (is_rx) rx_start = 1; else tx_wr = 1;
    if (inj == 4) rx_start = 1;
    @(negedge clk);
    tx_wr = 0; rx_start = 0;
    check(busy === 1'b1, "R10", "busy after start", busy, 1);
    prev_sclk = 1'b1; prev_sdo = sd_o; cyc = 0;
    forever begin
      s = sclk_o;
      if (prev_sclk && !s) begin
        falls++;
        if (falls > 1 && high_cnt != 2) high_bad++;
        low_cnt = 0;
        if (is_rx && falls <= 8) sd_i = data[falls-1];
      end
      if (!prev_sclk && s) begin
        rises++;
        if (low_cnt != exp_low) low_bad++;
        high_cnt = 0;
        if (!is_rx && rises <= 8) got[rises-1] = sd_o;
        last_rise = cyc;
      end
      if (!s) low_cnt++; else high_cnt++;
      if (!is_rx) begin
        if (cyc > 0 && sd_oe && sd_o !== prev_sdo && !(prev_sclk && !s)) order_bad++;
        if (rises < 8 && !sd_oe) oe_bad++;
        if (rises > 0 && !sd_oe && oe_drop < 0) oe_drop = cyc;
      end else if (sd_oe) oe_bad++;
      prev_sclk = s; prev_sdo = sd_o;
      if (!busy) begin busy_drop = cyc; break; end
      if (cyc > 4000) break;
      tx_wr = 0; rx_start = 0; clr_err = 0;
      if (inj != 0 && inj != 4 && cyc == inj_cyc) begin
        tx_byte = ~data;
        if (inj == 1 || inj == 3) tx_wr = 1;
        if (inj == 2) rx_start = 1;
        if (inj == 3) clr_err = 1;
      end
      @(negedge clk);
      cyc++;
    end
    tx_wr = 0; rx_start = 0; clr_err = 0;
    check(falls == 8, "R3", "falling edge count", falls, 8);
    check(rises == 8, "R3", "rising edge count", rises, 8);
    check(low_bad == 0, "R3", "low phase length errors", low_bad, 0);
    check(high_bad == 0, "R3", "high phase length errors", high_bad, 0);
    check(busy_drop == last_rise + 2, "R5", "busy drop after last rise", busy_drop - last_rise, 2);
    check(sclk_o === 1'b1, "R5", "clock idles high", sclk_o, 1);
    if (!is_rx) begin
      check(got == data, "R2", "transmitted byte LSB first", got, data);
      check(order_bad == 0, "R4", "data change off falling edge", order_bad, 0);
      check(oe_drop == last_rise + 1, "R5", "release after last rise", oe_drop - last_rise, 1);
      check(oe_bad == 0, "R2", "drive enable gaps", oe_bad, 0);
      check(tx_done === 1'b1 && rx_done === 1'b0, "R5", "tx_done/rx_done", {tx_done, rx_done}, 2);
    end else begin
      check(oe_bad == 0, "R6", "pin driven during receive", oe_bad, 0);
      check(rx_byte == data, "R6", "received byte", rx_byte, data);
      check(rx_done === 1'b1 && tx_done === 1'b0, "R6", "rx_done/tx_done", {rx_done, tx_done}, 2);
    end
    @(negedge clk);
    clr_tx_done = 1; clr_rx_done = 1;
    @(negedge clk);
    clr_tx_done = 0; clr_rx_done = 0;
    check(tx_done === 1'b0 && rx_done === 1'b0, "R9", "done flags cleared", {tx_done, rx_done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk_o === 1'b1 && sd_oe === 1'b0 && busy === 1'b0, "R1", "reset pins",
          {sclk_o, sd_oe, busy}, 3'b100);
    check(tx_done === 1'b0 && rx_done === 1'b0 && wr_err === 1'b0, "R1", "reset flags",
          {tx_done, rx_done, wr_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk_o === 1'b1 && busy === 1'b0, "R1", "idle after reset release", {sclk_o, busy}, 2'b10);

    for (int i = 0; i < NV; i++)
      run_xfer(VEC[i][24], VEC[i][23:8], VEC[i][7:0], 0, 0);

    // R7: transmit write during a transfer is dropped and flagged
    run_xfer(1'b0, 16'd2, 8'h96, 1, 9);
    check(wr_err === 1'b1, "R7", "error flag after busy write", wr_err, 1);
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
    check(wr_err === 1'b0, "R9", "error flag cleared", wr_err, 0);

    // R9: set and clear in the same cycle -> set wins
    run_xfer(1'b0, 16'd1, 8'h4B, 3, 5);
    check(wr_err === 1'b1, "R9", "set wins over clear", wr_err, 1);
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;

    // R8: receive start during transmit ignored (rx_done stays 0 inside run_xfer)
    run_xfer(1'b0, 16'd1, 8'hE1, 2, 6);
    check(wr_err === 1'b0, "R8", "rx start mid-transfer raises no error", wr_err, 0);

    // R8: simultaneous starts while idle -> transmit wins
    run_xfer(1'b0, 16'd1, 8'h2D, 4, 0);

    // R8: receive start during receive ignored, byte intact
    run_xfer(1'b1, 16'd1, 8'hB4, 2, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule